// File: doc/BRIEF.md
# Oversampling Serial Receiver with Multidrop Sleep

This block receives asynchronous serial characters on one data line. A parameterised divider makes a sample tick, and the line is sampled at sixteen times the bit rate. The block qualifies a start bit and assembles eight or nine data bits, least significant bit first. Each character is then presented on a valid/ready output stream, with eight data bits and a separate ninth bit. A framing error flag travels with every character.

On a multidrop bus, software can put the receiver to sleep so that it ignores traffic that is not meant for it. A wake-select input chooses how sleep ends. In idle-line mode, sleep ends when the line has stayed high for one full character time. In address-mark mode, sleep ends when a character arrives whose most significant bit is one, and that character is delivered.

The output stream works like a holding register. `rx_valid` stays high until a cycle with `rx_ready` high. There is no back-pressure into the line: a character that completes while an earlier one is still pending replaces it, and `rx_valid` stays high.

Top module: `sci_rx_wake`

## Requirements
- R1: With `cfg_len9`=0, a frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The frame's data appears on `rx_data` with `rx_valid`=1.
- R2: With `cfg_len9`=1, nine data bits follow the start bit. The ninth bit is loaded into `rx_bit8` in the same cycle that bits 0 to 7 are loaded into `rx_data`.
- R3: With `cfg_len9`=0, `rx_bit8` keeps its value across received characters.
- R4: `rx_valid` is 0 after reset. Once set, it stays 1 until a cycle with `rx_ready`=1, after which it is 0. A character that completes while one is pending overwrites `rx_data`.
- R5: A stop bit sampled as 0 sets `rx_ferr`=1 for that character, and the character is still delivered.
- R6: A low pulse on `rxd` shorter than half a bit time does not start a character.
- R7: Each data bit is the majority of three samples around the bit centre, so a one-sample glitch does not change it.
- R8: A `sleep_set` pulse makes `asleep`=1 from the next cycle. `asleep` is 0 after reset.
- R9: With `cfg_addr_wake`=0, characters that complete while `asleep`=1 are discarded. An idle line then clears `asleep`, and later characters are delivered.
- R10: With `cfg_addr_wake`=1 and `asleep`=1, a character whose most significant bit is 0 is discarded and the receiver stays asleep. The most significant bit is bit 8 when `cfg_len9`=1 and bit 7 otherwise. A character whose most significant bit is 1 clears `asleep` and is delivered. An idle line does not wake the receiver in this mode.
- R11: An idle condition is continuous high on `rxd` for 10 bit times (`cfg_len9`=0) or 11 bit times (`cfg_len9`=1).
- R12: Reset does not change `rx_bit8`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len9 | input | 1 | 1 = nine data bits, 0 = eight |
| cfg_addr_wake | input | 1 | 1 = address-mark wakeup, 0 = idle-line wakeup |
| sleep_set | input | 1 | One-cycle pulse that puts the receiver to sleep |
| asleep | output | 1 | Receiver sleeping; cleared by hardware on wakeup |
| rx_valid | output | 1 | Received character pending |
| rx_ready | input | 1 | Consumer accepts the pending character |
| rx_data | output | 8 | Received data bits 0 to 7 |
| rx_bit8 | output | 1 | Received ninth bit (9-bit mode), not reset |
| rx_ferr | output | 1 | Framing error for the pending character |

## Verification
The properties assume that `cfg_len9` and `cfg_addr_wake` do not change while the receiver sleeps or a frame is in flight. They also assume that `sleep_set` never arrives in the cycle a wakeup would occur. The stimulus changes the configuration only between frames, while the line is idle. It raises `sleep_set` only on an idle line with nothing arriving, so these assumptions hold throughout.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
  typedef enum logic {FR_IDLE, FR_RUN} fr_state_e;

  typedef struct packed {
    logic [8:0] bits;
    logic       ferr;
  } rx_char_t;
endpackage

// File: rtl/sci_rx_tick.sv
module sci_rx_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sci_rx_frame.sv
module sci_rx_frame
  import sci_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx_s,
  input  logic     len9,
  output logic     done,
  output rx_char_t chr
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] MID  = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] VB   = PW'(OVS / 2);
  localparam logic [PW-1:0] VC   = PW'(OVS / 2 + 1);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);

  fr_state_e     state;
  logic [PW-1:0] pos;
  logic [3:0]    idx;
  logic          s_a, s_b;
  logic [8:0]    shreg;
  logic [3:0]    nbits;
  logic          vote;

  assign nbits = len9 ? 4'd9 : 4'd8;
  assign vote  = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      pos   <= '0;
      idx   <= '0;
      s_a   <= 1'b1;
      s_b   <= 1'b1;
      shreg <= '0;
      done  <= 1'b0;
      chr   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          FR_IDLE: begin
            if (!rx_s) begin
              state <= FR_RUN;
              pos   <= PW'(1);
              idx   <= '0;
            end
          end
          default: begin
            pos <= pos + PW'(1);
            if (pos == LAST) idx <= idx + 4'd1;
            if (idx == 4'd0) begin
              // start bit is qualified by one sample at its centre
              if (pos == MID && rx_s) state <= FR_IDLE;
            end else begin
              if (pos == MID) s_a <= rx_s;
              if (pos == VB)  s_b <= rx_s;
              if (pos == VC) begin
                if (idx <= nbits) begin
                  for (int i = 0; i < 9; i++)
                    if (idx == 4'(i + 1)) shreg[i] <= vote;
                end else begin
                  chr.bits <= shreg;
                  chr.ferr <= ~vote;
                  done     <= 1'b1;
                  state    <= FR_IDLE;
                end
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sci_rx_idle.sv
module sci_rx_idle #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic len9,
  output logic idle_pulse
);
  localparam int CW = $clog2(OVS * 11 + 1);
  localparam logic [CW-1:0] THR8 = CW'(OVS * 10);
  localparam logic [CW-1:0] THR9 = CW'(OVS * 11);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;

  assign thr = len9 ? THR9 : THR8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= tick && rx_s && (cnt == thr - CW'(1));
      if (tick) begin
        if (!rx_s)         cnt <= '0;
        else if (cnt < thr) cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sci_rx_wake.sv
module sci_rx_wake
  import sci_rx_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       cfg_len9,
  input  logic       cfg_addr_wake,
  input  logic       sleep_set,
  output logic       asleep,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_ferr
);
  logic     sync1, rx_s;
  logic     tick, done, idle_pulse;
  rx_char_t chr;
  logic     msb, deliver, wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      sync1 <= rxd;
      rx_s  <= sync1;
    end
  end

  sci_rx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sci_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .len9(cfg_len9),
    .done(done), .chr(chr)
  );

  sci_rx_idle #(.OVS(OVS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .len9(cfg_len9),
    .idle_pulse(idle_pulse)
  );

  assign msb     = cfg_len9 ? chr.bits[8] : chr.bits[7];
  assign wake    = asleep && (cfg_addr_wake ? (done && msb) : idle_pulse);
  assign deliver = done && (!asleep || (cfg_addr_wake && msb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         asleep <= 1'b0;
    else if (sleep_set) asleep <= 1'b1;
    else if (wake)      asleep <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ferr  <= 1'b0;
    end else begin
      if (deliver) begin
        rx_valid <= 1'b1;
        rx_data  <= chr.bits[7:0];
        rx_ferr  <= chr.ferr;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // ninth bit survives reset
  always_ff @(posedge clk) begin
    if (deliver && cfg_len9) rx_bit8 <= chr.bits[8];
  end
endmodule

// File: rtl/sci_rx_wake_chk.sv
module sci_rx_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_len9,
  input logic cfg_addr_wake,
  input logic sleep_set,
  input logic asleep,
  input logic rx_valid,
  input logic rx_ready,
  input logic rx_bit8
);
  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  // R8
  sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_set |=> asleep);

  // R9
  idle_mode_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && !cfg_addr_wake |=> !$rose(rx_valid));

  // R10
  addr_wake_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) && cfg_addr_wake |-> rx_valid);

  // R3
  bit8_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_len9 |=> $stable(rx_bit8));
endmodule

bind sci_rx_wake sci_rx_wake_chk u_chk (.*);

// File: tb/test_sci_rx_wake.sv
module test_sci_rx_wake;
  localparam int BT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_len9 = 1'b1;
  logic       cfg_addr_wake = 1'b0;
  logic       sleep_set = 1'b0;
  logic       rx_ready = 1'b0;
  logic       asleep, rx_valid, rx_bit8, rx_ferr;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic exp_b8;

  always #4 clk = ~clk;

  sci_rx_wake #(.TICK_DIV(1), .OVS(16)) i_sci_rx_wake (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_len9(cfg_len9),
    .cfg_addr_wake(cfg_addr_wake), .sleep_set(sleep_set), .asleep(asleep),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_ferr(rx_ferr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BT) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1;
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic nine, input logic stopv, input int gbit);
    drive_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      if (i == gbit) begin
        rxd = d[i];  repeat (8) @(negedge clk);
        rxd = ~d[i]; @(negedge clk);
        rxd = d[i];  repeat (7) @(negedge clk);
      end else begin
        drive_bit(d[i]);
      end
    end
    drive_bit(stopv);
    rxd = 1'b1;
  endtask

  task automatic take(input string tag, input logic [7:0] ed, input logic eb8, input logic ef);
    for (int i = 0; i < 40 && !rx_valid; i++) @(negedge clk);
    chk({tag, " valid"}, 32'(rx_valid), 32'd1);
    chk({tag, " char"}, {23'd0, rx_bit8, rx_data}, {23'd0, eb8, ed});
    chk({tag, " ferr"}, 32'(rx_ferr), 32'(ef));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk({tag, " valid clear"}, 32'(rx_valid), 32'd0);
  endtask

  task automatic pulse_sleep();
    sleep_set = 1'b1;
    @(negedge clk);
    sleep_set = 1'b0;
    chk("R8 asleep after sleep_set", 32'(asleep), 32'd1);
  endtask

  initial begin
    for (int c = 0; c < 190000 && !done_flag; c++) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R4 valid after reset", 32'(rx_valid), 32'd0);
    chk("R8 asleep after reset", 32'(asleep), 32'd0);
    rst_n = 1'b1;
    idle_bits(2);

    // R2: nine-bit sweep
    cfg_len9 = 1'b1;
    for (int v = 0; v < 512; v += 3) begin
      send(9'(v), 1'b1, 1'b1, -1);
      take("R2 nine-bit", 8'(v), v[8], 1'b0);
      idle_bits(1);
    end

    // R12: ninth bit survives reset
    send(9'h1A5, 1'b1, 1'b1, -1);
    take("R2 nine-bit A5", 8'hA5, 1'b1, 1'b0);
    exp_b8 = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 bit8 kept over reset", 32'(rx_bit8), 32'(exp_b8));
    rst_n = 1'b1;
    idle_bits(2);

    // R1 / R3: eight-bit sweep
    cfg_len9 = 1'b0;
    idle_bits(1);
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 1'b0, 1'b1, -1);
      take("R1 R3 eight-bit", 8'(v), exp_b8, 1'b0);
      idle_bits(1);
    end

    // R5: framing error still delivers
    send(9'h05A, 1'b0, 1'b0, -1);
    take("R5 framing", 8'h5A, exp_b8, 1'b1);
    idle_bits(3);
    chk("R5 no stray char", 32'(rx_valid), 32'd0);

    // R4: overwrite while pending
    send(9'h011, 1'b0, 1'b1, -1);
    idle_bits(1);
    send(9'h022, 1'b0, 1'b1, -1);
    idle_bits(1);
    chk("R4 still pending", 32'(rx_valid), 32'd1);
    take("R4 overwrite", 8'h22, exp_b8, 1'b0);

    // R6: short low pulse
    rxd = 1'b0; repeat (5) @(negedge clk);
    idle_bits(15);
    chk("R6 glitch no char", 32'(rx_valid), 32'd0);

    // R7: one-sample glitches at bit centres
    for (int g = 0; g < 8; g++) begin
      send(9'h000, 1'b0, 1'b1, g);
      take("R7 vote zeros", 8'h00, exp_b8, 1'b0);
      idle_bits(1);
      send(9'h0FF, 1'b0, 1'b1, g);
      take("R7 vote ones", 8'hFF, exp_b8, 1'b0);
      idle_bits(1);
    end

    // R9 / R11: idle wakeup, eight-bit
    cfg_addr_wake = 1'b0;
    idle_bits(12);
    pulse_sleep();
    send(9'h03C, 1'b0, 1'b1, -1);
    repeat (2) @(negedge clk);
    chk("R9 discarded while asleep", 32'(rx_valid), 32'd0);
    repeat (118) @(negedge clk);
    chk("R11 asleep before 10 bit idle", 32'(asleep), 32'd1);
    repeat (40) @(negedge clk);
    chk("R9 R11 idle wake 8-bit", 32'(asleep), 32'd0);
    send(9'h077, 1'b0, 1'b1, -1);
    take("R9 after wake", 8'h77, exp_b8, 1'b0);

    // R11: idle length in nine-bit mode
    cfg_len9 = 1'b1;
    idle_bits(12);
    pulse_sleep();
    send(9'h0C3, 1'b1, 1'b1, -1);
    repeat (2) @(negedge clk);
    chk("R9 discarded nine-bit", 32'(rx_valid), 32'd0);
    repeat (148) @(negedge clk);
    chk("R11 asleep before 11 bit idle", 32'(asleep), 32'd1);
    repeat (25) @(negedge clk);
    chk("R11 idle wake 9-bit", 32'(asleep), 32'd0);

    // R10: address mark, eight-bit (msb = bit 7)
    cfg_len9 = 1'b0;
    cfg_addr_wake = 1'b1;
    idle_bits(12);
    pulse_sleep();
    send(9'h041, 1'b0, 1'b1, -1);
    idle_bits(14);
    chk("R10 msb0 discarded", 32'(rx_valid), 32'd0);
    chk("R10 idle no wake", 32'(asleep), 32'd1);
    send(9'h085, 1'b0, 1'b1, -1);
    @(negedge clk);
    chk("R10 woke 8-bit", 32'(asleep), 32'd0);
    take("R10 address 8-bit", 8'h85, exp_b8, 1'b0);

    // R10: address mark, nine-bit (msb = bit 8)
    cfg_len9 = 1'b1;
    idle_bits(2);
    pulse_sleep();
    send(9'h0FF, 1'b1, 1'b1, -1);
    idle_bits(2);
    chk("R10 bit7 not mark in 9-bit", 32'(rx_valid), 32'd0);
    chk("R10 still asleep", 32'(asleep), 32'd1);
    send(9'h101, 1'b1, 1'b1, -1);
    @(negedge clk);
    chk("R10 woke 9-bit", 32'(asleep), 32'd0);
    take("R10 R2 address 9-bit", 8'h01, 1'b1, 1'b0);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule